// File: doc/BRIEF.md
# Triggered Slice Trace Sequencer

The block keeps a small library of packed instruction traces, each one keyed by a trigger program counter. It watches the program counters retired or fetched by the main thread. When a valid main-thread PC equals the key of a committed trace, the block forks a helper context. It then hands that trace's instructions, one at a time and in stored order, to a helper-thread issue port. The trigger instruction itself belongs to the main thread. Only the instructions that follow it in the slice are held in the trace.

Emission is driven purely by the packed data. Every stored word is issued, whether it encodes an arithmetic operation, a load or a branch. No branch outcome ever changes the sequence, so a helper always ends after exactly the stored number of instructions. Each issued word carries its trace slot and position. A downstream consumer can use these to keep the result for later integration into the main thread.

Traces are written ahead of use through a small load port, one operation per cycle. Only one helper runs at a time. A trigger that arrives while a helper is busy is dropped and counted. A control state machine has three states:
- IDLE: no helper is active.
- EMIT: the active trace is being issued.
- DONE: a one-cycle completion pulse.

Its transitions are:
- IDLE→EMIT on a fork of a non-empty trace.
- IDLE→DONE on a fork of an empty trace.
- EMIT→EMIT while instructions remain or the port stalls.
- EMIT→DONE when the last instruction is accepted.
- DONE→IDLE unconditionally.

Top module: `slice_trace_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, `hp_valid`, `busy` and `done` are 0 and `drop_count` is 0.
- R2: When `mt_valid` is 1, `mt_pc` equals the tag of a committed slot, and no helper is busy, a fork occurs. On the next cycle `busy` is 1, and for a non-empty trace `hp_valid` is 1 with `hp_slot` set to that slot and `hp_index` set to 0. A PC that matches no committed tag causes no fork.
- R3: Instructions are issued in index order 0, 1, … with `hp_insn` equal to the word stored at (`hp_slot`, `hp_index`). The index advances only on a cycle where `hp_valid` and `hp_ready` are both 1. While the port stalls, the slot and index are held.
- R4: Exactly the stored number of instructions is issued per fork, whatever their contents. After the last one is accepted, `hp_valid` is 0.
- R5: `done` is 1 for exactly one cycle: the cycle after the last instruction is accepted. On the following cycle `busy` is 0.
- R6: A trigger match with `mt_valid` = 1 while `busy` = 1 starts no fork and does not disturb the active helper. It increments `drop_count` by one, saturating at all ones (255 by default).
- R7: The `ld_kind` encoding selects the load operation:
  - 0: no operation.
  - 1: header. Writes the slot's tag from `ld_tag` and its length from `ld_len`, and clears the slot's valid bit.
  - 2: instruction. Writes `ld_word` at index `ld_index` of the slot.
  - 3: commit. Sets the slot's valid bit.

  A slot whose header has been written but not yet committed, or that is the target of a load operation in the current cycle, cannot trigger.
- R8: When several committed slots hold the PC, the lowest-numbered slot is forked.
- R9: A committed trace of length 0 produces `done` on the cycle after the fork, with `hp_valid` remaining 0.
- R10: A header length above the trace capacity (32) is stored as the capacity.
- R11: With `mt_valid` = 0 no fork occurs, whatever `mt_pc` holds.

Ports (the Width column uses the default parameters):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load operation present this cycle |
| ld_kind | input | 2 | Load operation: 0 none, 1 header, 2 instruction, 3 commit |
| ld_slot | input | 4 | Target trace slot |
| ld_index | input | 5 | Instruction position for an instruction write |
| ld_tag | input | 32 | Trigger PC for a header write |
| ld_len | input | 6 | Trace length for a header write |
| ld_word | input | 32 | Instruction word for an instruction write |
| mt_valid | input | 1 | Main-thread PC valid |
| mt_pc | input | 32 | Main-thread program counter |
| hp_valid | output | 1 | Helper instruction available |
| hp_ready | input | 1 | Helper port accepts the instruction |
| hp_slot | output | 4 | Slot of the active trace |
| hp_index | output | 5 | Position of the issued instruction in the trace |
| hp_insn | output | 32 | Issued instruction word |
| busy | output | 1 | A helper is active (EMIT or DONE) |
| done | output | 1 | One-cycle pulse after the last instruction |
| drop_count | output | 8 | Saturating count of forks dropped while busy |

## Verification
A fork is visible one clock after the matching PC is sampled, as `busy`, `hp_valid`, index 0, or `done` for an empty trace. Each accepted instruction advances `hp_index` one clock later. `done` follows the last acceptance by one clock, and `busy` falls one clock after that. `drop_count` updates one clock after the dropped trigger. The bench drives all inputs just after a falling edge and samples outputs at the next falling edge, so every check lands in the first cycle where its result is due. The bench also checks the held cycles around a stall, so that an early or late result is reported.

// File: rtl/sts_pkg.sv
package sts_pkg;

    // Load-port operation codes
    typedef enum logic [1:0] {
        LD_NOP    = 2'd0,
        LD_HEADER = 2'd1,
        LD_WORD   = 2'd2,
        LD_COMMIT = 2'd3
    } ld_kind_e;

    // Helper sequencing states
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EMIT = 2'd1,
        S_DONE = 2'd2
    } emit_state_e;

endpackage

// File: rtl/sts_trace_store.sv
module sts_trace_store
    import sts_pkg::*;
#(
    parameter int NUM_TRACES = 16,
    parameter int MAX_LEN    = 32,
    parameter int PC_W       = 32,
    parameter int INSN_W     = 32,
    localparam int SLOT_W    = $clog2(NUM_TRACES),
    localparam int IDX_W     = $clog2(MAX_LEN),
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ld_valid,
    input  ld_kind_e                         ld_kind,
    input  logic [SLOT_W-1:0]                ld_slot,
    input  logic [IDX_W-1:0]                 ld_index,
    input  logic [PC_W-1:0]                  ld_tag,
    input  logic [LEN_W-1:0]                 ld_len,
    input  logic [INSN_W-1:0]                ld_word,
    input  logic [SLOT_W-1:0]                rd_slot,
    input  logic [IDX_W-1:0]                 rd_index,
    output logic [INSN_W-1:0]                rd_word,
    output logic [NUM_TRACES-1:0]            slot_valid,
    output logic [NUM_TRACES-1:0][PC_W-1:0]  slot_tag,
    output logic [NUM_TRACES-1:0][LEN_W-1:0] slot_len
);

    localparam int DEPTH  = NUM_TRACES * MAX_LEN;
    localparam int ADDR_W = SLOT_W + IDX_W;

    logic [INSN_W-1:0] mem [DEPTH];
    logic [LEN_W-1:0]  len_clamped;

    assign len_clamped = (ld_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : ld_len;

    // Instruction storage: slot selects a block of MAX_LEN words
    always_ff @(posedge clk) begin
        if (ld_valid && ld_kind == LD_WORD) begin
            mem[ADDR_W'({ld_slot, ld_index})] <= ld_word;
        end
    end

    assign rd_word = mem[ADDR_W'({rd_slot, rd_index})];

    // Per-slot key, length and valid bit
    for (genvar s = 0; s < NUM_TRACES; s++) begin : g_slot
        logic             v_q;
        logic [PC_W-1:0]  t_q;
        logic [LEN_W-1:0] l_q;
        logic             sel;

        assign sel = ld_valid && (ld_slot == SLOT_W'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                t_q <= '0;
                l_q <= '0;
            end else if (sel) begin
                if (ld_kind == LD_HEADER) begin
                    t_q <= ld_tag;
                    l_q <= len_clamped;
                    v_q <= 1'b0;
                end else if (ld_kind == LD_COMMIT) begin
                    v_q <= 1'b1;
                end
            end
        end

        assign slot_valid[s] = v_q;
        assign slot_tag[s]   = t_q;
        assign slot_len[s]   = l_q;
    end

    // R7: commit makes the slot live, header retires it
    a_r7_commit_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_kind == LD_COMMIT) |=> slot_valid[$past(ld_slot)]);
    a_r7_header_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_kind == LD_HEADER) |=> !slot_valid[$past(ld_slot)]);
    // R10: stored length never exceeds capacity
    a_r10_len_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_kind == LD_HEADER) |=> (slot_len[$past(ld_slot)] <= LEN_W'(MAX_LEN)));

endmodule

// File: rtl/sts_trigger_cam.sv
module sts_trigger_cam #(
    parameter int NUM_TRACES = 16,
    parameter int PC_W       = 32,
    localparam int SLOT_W    = $clog2(NUM_TRACES)
) (
    input  logic                            pc_valid,
    input  logic [PC_W-1:0]                 pc,
    input  logic [NUM_TRACES-1:0]           slot_valid,
    input  logic [NUM_TRACES-1:0][PC_W-1:0] slot_tag,
    input  logic                            wr_active,
    input  logic [SLOT_W-1:0]               wr_slot,
    output logic                            hit,
    output logic [SLOT_W-1:0]               hit_slot
);

    logic [NUM_TRACES-1:0] cand;

    // One comparator per slot; a slot under load is masked out
    for (genvar s = 0; s < NUM_TRACES; s++) begin : g_cmp
        assign cand[s] = pc_valid && slot_valid[s] && (slot_tag[s] == pc)
                         && !(wr_active && wr_slot == SLOT_W'(s));
    end

    // Lowest-numbered candidate wins
    always_comb begin
        hit      = 1'b0;
        hit_slot = '0;
        for (int s = NUM_TRACES - 1; s >= 0; s--) begin
            if (cand[s]) begin
                hit      = 1'b1;
                hit_slot = SLOT_W'(s);
            end
        end
    end

    // R11: no candidate without a valid PC
    always_comb begin
        a_r11_no_hit_idle: assert (pc_valid || !hit);
    end

endmodule

// File: rtl/sts_emit_fsm.sv
module sts_emit_fsm
    import sts_pkg::*;
#(
    parameter int NUM_TRACES = 16,
    parameter int MAX_LEN    = 32,
    localparam int SLOT_W    = $clog2(NUM_TRACES),
    localparam int IDX_W     = $clog2(MAX_LEN),
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fork_req,
    input  logic [SLOT_W-1:0] fork_slot,
    input  logic [LEN_W-1:0]  fork_len,
    input  logic              hp_ready,
    output logic              hp_valid,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [IDX_W-1:0]  cur_index,
    output logic              busy,
    output logic              done
);

    emit_state_e       state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic [LEN_W-1:0]  len_q;
    logic [IDX_W-1:0]  idx_q;
    logic              last;

    assign last = (LEN_W'(idx_q) + LEN_W'(1)) == len_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (fork_req) state_d = (fork_len == '0) ? S_DONE : S_EMIT;
            S_EMIT: if (hp_ready && last) state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Helper context: slot, length and position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
            len_q  <= '0;
            idx_q  <= '0;
        end else if (state_q == S_IDLE && fork_req) begin
            slot_q <= fork_slot;
            len_q  <= fork_len;
            idx_q  <= '0;
        end else if (state_q == S_EMIT && hp_ready && !last) begin
            idx_q  <= idx_q + IDX_W'(1);
        end
    end

    // Outputs
    always_comb begin
        hp_valid  = 1'b0;
        done      = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            S_IDLE: busy = 1'b0;
            S_EMIT: hp_valid = 1'b1;
            S_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
        cur_slot  = slot_q;
        cur_index = idx_q;
    end

    // R3: a stalled instruction stays put
    a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_valid && !hp_ready) |=> (hp_valid && $stable(cur_index) && $stable(cur_slot)));
    // R4: position never reaches the stored length
    a_r4_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        hp_valid |-> (LEN_W'(cur_index) < len_q));
    // R5: completion follows the last acceptance and lasts one cycle
    a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_valid && hp_ready && last) |=> (done && !hp_valid));
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    // R9: an empty trace completes at once
    a_r9_empty_trace: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fork_req && fork_len == '0) |=> (done && !hp_valid));

endmodule

// File: rtl/slice_trace_sequencer.sv
module slice_trace_sequencer
    import sts_pkg::*;
#(
    parameter int NUM_TRACES = 16,
    parameter int MAX_LEN    = 32,
    parameter int PC_W       = 32,
    parameter int INSN_W     = 32,
    parameter int DROP_W     = 8,
    localparam int SLOT_W    = $clog2(NUM_TRACES),
    localparam int IDX_W     = $clog2(MAX_LEN),
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [1:0]        ld_kind,
    input  logic [SLOT_W-1:0] ld_slot,
    input  logic [IDX_W-1:0]  ld_index,
    input  logic [PC_W-1:0]   ld_tag,
    input  logic [LEN_W-1:0]  ld_len,
    input  logic [INSN_W-1:0] ld_word,
    input  logic              mt_valid,
    input  logic [PC_W-1:0]   mt_pc,
    output logic              hp_valid,
    input  logic              hp_ready,
    output logic [SLOT_W-1:0] hp_slot,
    output logic [IDX_W-1:0]  hp_index,
    output logic [INSN_W-1:0] hp_insn,
    output logic              busy,
    output logic              done,
    output logic [DROP_W-1:0] drop_count
);

    ld_kind_e                         kind;
    logic [NUM_TRACES-1:0]            slot_valid;
    logic [NUM_TRACES-1:0][PC_W-1:0]  slot_tag;
    logic [NUM_TRACES-1:0][LEN_W-1:0] slot_len;
    logic                             hit;
    logic [SLOT_W-1:0]                hit_slot;
    logic                             wr_active;
    logic                             fork_req;
    logic                             drop_evt;
    logic [DROP_W-1:0]                drop_q;

    assign kind      = ld_kind_e'(ld_kind);
    assign wr_active = ld_valid && (kind != LD_NOP);

    sts_trace_store #(
        .NUM_TRACES(NUM_TRACES), .MAX_LEN(MAX_LEN), .PC_W(PC_W), .INSN_W(INSN_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_kind(kind), .ld_slot(ld_slot), .ld_index(ld_index),
        .ld_tag(ld_tag), .ld_len(ld_len), .ld_word(ld_word),
        .rd_slot(hp_slot), .rd_index(hp_index), .rd_word(hp_insn),
        .slot_valid(slot_valid), .slot_tag(slot_tag), .slot_len(slot_len)
    );

    sts_trigger_cam #(
        .NUM_TRACES(NUM_TRACES), .PC_W(PC_W)
    ) u_cam (
        .pc_valid(mt_valid), .pc(mt_pc),
        .slot_valid(slot_valid), .slot_tag(slot_tag),
        .wr_active(wr_active), .wr_slot(ld_slot),
        .hit(hit), .hit_slot(hit_slot)
    );

    assign fork_req = hit && !busy;
    assign drop_evt = hit && busy;

    sts_emit_fsm #(
        .NUM_TRACES(NUM_TRACES), .MAX_LEN(MAX_LEN)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .fork_req(fork_req), .fork_slot(hit_slot), .fork_len(slot_len[hit_slot]),
        .hp_ready(hp_ready), .hp_valid(hp_valid),
        .cur_slot(hp_slot), .cur_index(hp_index),
        .busy(busy), .done(done)
    );

    // Saturating count of forks refused while a helper runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     drop_q <= '0;
        else if (drop_evt && !(&drop_q)) drop_q <= drop_q + DROP_W'(1);
    end
    assign drop_count = drop_q;

    // R6: each refused fork is counted once, up to saturation
    a_r6_drop_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_valid && hit && busy) |=>
            ((drop_count == $past(drop_count) + DROP_W'(1)) || (&$past(drop_count))));
    // R6: a refused fork leaves the active helper untouched
    a_r6_helper_undisturbed: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_valid && !hp_ready && hit) |=> (hp_valid && $stable(hp_slot)));
    // R2: a fork of a non-empty trace starts at index 0
    a_r2_fork_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (fork_req && slot_len[hit_slot] != '0) |=> (hp_valid && hp_index == '0));
    // R11: an idle block stays idle without a valid PC
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!mt_valid && !busy) |=> !busy);

endmodule

// File: tb/test_slice_trace_sequencer.sv
module test_slice_trace_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [1:0]  ld_kind = 2'd0;
    logic [3:0]  ld_slot = '0;
    logic [4:0]  ld_index = '0;
    logic [31:0] ld_tag = '0;
    logic [5:0]  ld_len = '0;
    logic [31:0] ld_word = '0;
    logic        mt_valid = 1'b0;
    logic [31:0] mt_pc = '0;
    logic        hp_valid;
    logic        hp_ready = 1'b1;
    logic [3:0]  hp_slot;
    logic [4:0]  hp_index;
    logic [31:0] hp_insn;
    logic        busy;
    logic        done;
    logic [7:0]  drop_count;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    slice_trace_sequencer i_slice_trace_sequencer (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_kind(ld_kind), .ld_slot(ld_slot), .ld_index(ld_index),
        .ld_tag(ld_tag), .ld_len(ld_len), .ld_word(ld_word),
        .mt_valid(mt_valid), .mt_pc(mt_pc),
        .hp_valid(hp_valid), .hp_ready(hp_ready), .hp_slot(hp_slot),
        .hp_index(hp_index), .hp_insn(hp_insn),
        .busy(busy), .done(done), .drop_count(drop_count)
    );

    typedef struct packed {
        logic [31:0] pc;
        logic        fk;
        logic [3:0]  slot;
        logic [5:0]  len;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_1000, 1'b1, 4'd0, 6'd3},   // R8: slot 2 shares this tag
        '{32'h0000_2000, 1'b1, 4'd1, 6'd5},
        '{32'h0000_5000, 1'b0, 4'd0, 6'd0},   // R7: header only, never committed
        '{32'h0000_1234, 1'b0, 4'd0, 6'd0},   // R2: no tag
        '{32'h0000_4000, 1'b1, 4'd4, 6'd32},  // R10: loaded with 40
        '{32'h0000_2000, 1'b1, 4'd1, 6'd5}
    };

    function automatic logic [31:0] wgen(input int s, input int i);
        return 32'hB000_0000 | (32'(s) << 8) | 32'(i);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_op(input logic [1:0] k, input int s, input int i,
                           input logic [31:0] tag, input int len, input logic [31:0] w);
        ld_valid = 1'b1; ld_kind = k; ld_slot = 4'(s); ld_index = 5'(i);
        ld_tag = tag; ld_len = 6'(len); ld_word = w;
        @(negedge clk);
        ld_valid = 1'b0; ld_kind = 2'd0;
    endtask

    task automatic load_trace(input int s, input logic [31:0] tag, input int len, input bit commit);
        int nw;
        nw = (len > 32) ? 32 : len;
        load_op(2'd1, s, 0, tag, len, '0);
        for (int i = 0; i < nw; i++) load_op(2'd2, s, i, '0, 0, wgen(s, i));
        if (commit) load_op(2'd3, s, 0, '0, 0, '0);
    endtask

    task automatic fire(input logic [31:0] pc);
        mt_valid = 1'b1; mt_pc = pc;
        @(negedge clk);
        mt_valid = 1'b0;
    endtask

    // Called at the cycle where index 0 is first visible, with hp_ready = 1
    task automatic drain(input int s, input int len);
        for (int k = 0; k < len; k++) begin
            chk(hp_valid && hp_slot == 4'(s) && hp_index == 5'(k) && hp_insn == wgen(s, k),
                "R3 in-order issue", {27'd0, hp_index, hp_insn}, {27'(k), wgen(s, k)});
            @(negedge clk);
        end
        chk(done && !hp_valid, "R4/R5 done after last, no extra issue",
            {hp_valid, done}, 2'b01);
        @(negedge clk);
        chk(!busy && !done, "R5 idle after done pulse", {busy, done}, 2'b00);
    endtask

    initial begin
        #(8 * 150000);
        if (!ended) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk(!hp_valid && !busy && !done && drop_count == 0, "R1 reset state",
            {hp_valid, busy, done, drop_count}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!hp_valid && !busy && !done && drop_count == 0, "R1 after release",
            {hp_valid, busy, done, drop_count}, '0);

        load_trace(0, 32'h1000, 3, 1'b1);
        load_trace(1, 32'h2000, 5, 1'b1);
        load_trace(2, 32'h1000, 7, 1'b1);
        load_trace(3, 32'h3000, 0, 1'b1);
        load_trace(4, 32'h4000, 40, 1'b1);
        load_trace(5, 32'h5000, 4, 1'b0);

        // Vector table: PC, expected fork, slot, length
        for (int v = 0; v < NVEC; v++) begin
            fire(VECS[v].pc);
            if (VECS[v].fk) begin
                chk(busy, "R2 fork raises busy", busy, 1);
                drain(int'(VECS[v].slot), int'(VECS[v].len));
            end else begin
                chk(!busy && !hp_valid && !done, "R2/R7 no fork on non-live tag",
                    {busy, hp_valid, done}, 3'b000);
            end
        end
        chk(drop_count == 0, "R6 no drop while idle", drop_count, 0);

        // R11: matching PC without valid
        mt_pc = 32'h1000;
        @(negedge clk);
        chk(!busy && !hp_valid, "R11 no fork without mt_valid", {busy, hp_valid}, 2'b00);

        // R9: empty trace
        fire(32'h3000);
        chk(done && !hp_valid && busy, "R9 empty trace done at once", {busy, hp_valid, done}, 3'b101);
        @(negedge clk);
        chk(!busy && !done, "R9 idle after empty trace", {busy, done}, 2'b00);

        // R3: stall holds position and word
        hp_ready = 1'b0;
        fire(32'h2000);
        for (int c = 0; c < 3; c++) begin
            chk(hp_valid && hp_index == 0 && hp_insn == wgen(1, 0), "R3 hold under stall",
                {hp_index, hp_insn}, {5'd0, wgen(1, 0)});
            @(negedge clk);
        end
        hp_ready = 1'b1;
        drain(1, 5);

        // R7: a fresh header retires a slot until committed
        load_op(2'd1, 1, 0, 32'h2000, 5, '0);
        fire(32'h2000);
        chk(!busy && !hp_valid, "R7 uncommitted slot cannot trigger", {busy, hp_valid}, 2'b00);
        load_op(2'd3, 1, 0, '0, 0, '0);
        fire(32'h2000);
        drain(1, 5);

        // R7: slot under load in the same cycle is masked
        ld_valid = 1'b1; ld_kind = 2'd2; ld_slot = 4'd1; ld_index = 5'd0; ld_word = wgen(1, 0);
        fire(32'h2000);
        ld_valid = 1'b0; ld_kind = 2'd0;
        chk(!busy, "R7 slot being written cannot trigger", busy, 0);

        // R6: drops while busy, then saturation
        hp_ready = 1'b0;
        fire(32'h4000);
        fire(32'h1000);
        fire(32'h2000);
        chk(drop_count == 2, "R6 drop counted", drop_count, 2);
        chk(hp_valid && hp_slot == 4 && hp_index == 0, "R6 helper undisturbed",
            {hp_slot, hp_index}, {4'd4, 5'd0});
        mt_valid = 1'b1; mt_pc = 32'h1000;
        for (int c = 0; c < 300; c++) @(negedge clk);
        mt_valid = 1'b0;
        chk(drop_count == 8'd255, "R6 drop count saturates", drop_count, 255);
        hp_ready = 1'b1;
        drain(4, 32);

        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule